// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block sits between a controller and a byte-level bus cycle engine that drives a NAND flash device. A request names one of six operations (page read, page program, block erase, status read, identifier read, device reset), together with a row address, a column address and a byte count. The block expands the request into the required series of command, address and data cycles and hands each one to the engine. Between cycles it watches the ready/busy line, and after a program or erase it polls the status register to decide whether the operation passed.

Page data moves on two byte-wide valid/ready streams. Program data enters on the write stream. A byte is taken only in a cycle where both `wr_valid` and `wr_ready` are high, and `wr_ready` follows the engine's acceptance of the data cycle. Read and identifier bytes leave on the read stream. Once `rd_valid` rises, it and `rd_data` hold until `rd_ready` is seen high. No further read cycle goes to the engine while the output byte has not been taken, so a stalled consumer pauses the flash transfer without losing data.

A small record of recently programmed pages is kept. A second program of a recorded page is refused until an erase of the page's block clears the entry. A programmable limit bounds how long the device may stay busy.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, `req_ready`=1, and `busy`, `done`, `cyc_valid`, `rd_valid`, `op_fail` and `op_tmo` are all 0.
- R2: A page read (op code 0) issues command 00h, then five address bytes (col[7:0], col[15:8], row[7:0], row[15:8], row[23:16]), then command 30h. After the wait it issues `req_len` read cycles, and the returned bytes appear on the read stream in order. Cycle kinds are 0 command, 1 address, 2 write data, 3 read data.
- R3: A page program (op code 1) issues 80h, the same five address bytes, `req_len` write cycles carrying the write-stream bytes in order, then 10h. After the wait it issues 70h and reads status bytes until one has bit 6 set. Bit 0 of that byte becomes `op_fail`.
- R4: A block erase (op code 2) issues 60h, the three row bytes, then D0h, and then performs the same status polling as a program. It clears the program record of every page in the same block, where the block is row bits above PAGE_BITS.
- R5: A program of a page that was already programmed and not erased since is refused. No bus cycle is issued, `done` pulses and `op_fail`=1.
- R6: A status read (op code 3) issues 70h and one read cycle, and delivers that byte on the read stream.
- R7: An identifier read (op code 4) issues 90h, one address byte of 00h, then `req_len` read cycles delivered on the read stream.
- R8: A device reset (op code 5) issues FFh, waits for the device to become ready, and completes with `op_fail`=0.
- R9: If the ready/busy line stays low for `tmo_limit` cycles of a wait, the operation ends with `op_tmo`=1 and issues no further bus cycle.
- R10: From the cycle after a request is accepted until the operation completes, `req_ready`=0 and `busy`=1.
- R11: A read byte holds on the read stream until taken, and no read cycle is issued meanwhile. A command, address or read cycle offered to the engine holds its kind and byte until accepted.
- R12: `done` is a single-cycle pulse. `op_fail` and `op_tmo` hold their values until the next request is accepted.
- R13: The ready/busy line is ignored for the first SETTLE cycles of each wait, so a device that has not yet dropped the line is not taken as finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | Operation code (0 read, 1 program, 2 erase, 3 status, 4 identifier, 5 reset) |
| req_row | input | ROW_W | Row (block and page) address |
| req_col | input | COL_W | Column address |
| req_len | input | LEN_W | Data byte count (0 is treated as 1) |
| tmo_limit | input | TMO_W | Busy wait limit in cycles |
| cyc_valid | output | 1 | Bus cycle offered to the engine |
| cyc_ready | input | 1 | Engine accepts the cycle |
| cyc_kind | output | 2 | Cycle kind: 0 command, 1 address, 2 write, 3 read |
| cyc_byte | output | 8 | Command, address or write byte |
| eng_rvalid | input | 1 | Engine returns a read byte |
| eng_rdata | input | 8 | Byte read by the engine |
| rb_n | input | 1 | Device ready (1) or busy (0) |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Write stream byte taken |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Read stream consumer ready |
| rd_data | output | 8 | Read stream byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| op_fail | output | 1 | Last operation failed or was refused |
| op_tmo | output | 1 | Last operation timed out |

## Verification
`busy` and the loss of `req_ready` are due in the first cycle after the accepting edge, so the bench samples them at the next falling edge. Bus cycles, stream bytes and their edge numbers are logged at each handshake edge. Each sequence is compared only after `done` is seen, and `done` rises one cycle after the final status byte, the final read byte, or the end of the wait. `op_fail` and `op_tmo` are read in that same `done` cycle, and `done` is sampled again one cycle later to confirm it is a pulse. The settle window and the reset wait are checked as minimum gaps in edges between the command that starts the busy period and the next bus cycle or `done`. These minimums are derived from the delay and length of the bench's busy model.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ERASE = 3'd2,
    OP_STAT  = 3'd3,
    OP_ID    = 3'd4,
    OP_RESET = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    CK_CMD  = 2'd0,
    CK_ADDR = 2'd1,
    CK_WR   = 2'd2,
    CK_RD   = 2'd3
  } cyc_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WAIT,
    S_STCMD, S_STRD, S_STWAIT, S_RDATA, S_RWAIT, S_FINISH
  } st_e;

  localparam logic [7:0] C_READ1  = 8'h00;
  localparam logic [7:0] C_READ2  = 8'h30;
  localparam logic [7:0] C_PROG1  = 8'h80;
  localparam logic [7:0] C_PROG2  = 8'h10;
  localparam logic [7:0] C_ERASE1 = 8'h60;
  localparam logic [7:0] C_ERASE2 = 8'hD0;
  localparam logic [7:0] C_STATUS = 8'h70;
  localparam logic [7:0] C_IDENT  = 8'h90;
  localparam logic [7:0] C_RESET  = 8'hFF;

  localparam int ST_RDY_BIT  = 6;
  localparam int ST_FAIL_BIT = 0;
endpackage

// File: rtl/nseq_addr_mux.sv
module nseq_addr_mux #(
  parameter int COL_W = 16,
  parameter int ROW_W = 24
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic [2:0]       idx,
  output logic [7:0]       abyte
);
  logic [15:0] c16;
  logic [23:0] r24;

  assign c16 = 16'(col);
  assign r24 = 24'(row);

  always_comb begin
    case (idx)
      3'd0:    abyte = c16[7:0];
      3'd1:    abyte = c16[15:8];
      3'd2:    abyte = r24[7:0];
      3'd3:    abyte = r24[15:8];
      3'd4:    abyte = r24[23:16];
      default: abyte = 8'h00;
    endcase
  end
endmodule

// File: rtl/nseq_busy_timer.sv
module nseq_busy_timer #(
  parameter int TMO_W  = 20,
  parameter int SETTLE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rb_n,
  input  logic [TMO_W-1:0] limit,
  output logic             ready,
  output logic             expired
);
  localparam logic [TMO_W-1:0] SETTLE_C = TMO_W'(SETTLE);
  localparam logic [TMO_W-1:0] CNT_MAX  = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;
  logic             settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign settled = cnt_q >= SETTLE_C;
  assign ready   = run && settled && rb_n;
  assign expired = run && settled && (cnt_q >= limit) && !rb_n;
endmodule

// File: rtl/nseq_prog_guard.sv
module nseq_prog_guard #(
  parameter int ROW_W     = 24,
  parameter int PAGE_BITS = 8,
  parameter int TRACK_N   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] chk_row,
  output logic             hit,
  input  logic             rec_en,
  input  logic [ROW_W-1:0] rec_row,
  input  logic             clr_en,
  input  logic [ROW_W-1:0] clr_row
);
  localparam int PTR_W = (TRACK_N > 1) ? $clog2(TRACK_N) : 1;

  logic [ROW_W-1:0]   rows_q [TRACK_N];
  logic [TRACK_N-1:0] vld_q;
  logic [TRACK_N-1:0] match;
  logic [PTR_W-1:0]   ptr_q;

  for (genvar i = 0; i < TRACK_N; i++) begin : g_ent
    assign match[i] = vld_q[i] && (rows_q[i] == chk_row);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i]  <= 1'b0;
        rows_q[i] <= '0;
      end else if (rec_en && ptr_q == PTR_W'(i)) begin
        vld_q[i]  <= 1'b1;
        rows_q[i] <= rec_row;
      end else if (clr_en && rows_q[i][ROW_W-1:PAGE_BITS] == clr_row[ROW_W-1:PAGE_BITS]) begin
        vld_q[i]  <= 1'b0;
      end
    end
  end

  assign hit = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (rec_en) ptr_q <= (ptr_q == PTR_W'(TRACK_N - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R5
  no_dup_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_en && rec_row == chk_row) |-> !hit);
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq #(
  parameter int COL_W     = 16,
  parameter int ROW_W     = 24,
  parameter int PAGE_BITS = 8,
  parameter int LEN_W     = 14,
  parameter int TMO_W     = 20,
  parameter int SETTLE    = 4,
  parameter int TRACK_N   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             cyc_valid,
  input  logic             cyc_ready,
  output logic [1:0]       cyc_kind,
  output logic [7:0]       cyc_byte,
  input  logic             eng_rvalid,
  input  logic [7:0]       eng_rdata,
  input  logic             rb_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             op_fail,
  output logic             op_tmo
);
  import nseq_pkg::*;

  st_e              state_q;
  op_e              op_q, req_op_e;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [LEN_W:0]   cnt_nxt;
  logic [2:0]       aidx_q, alast_q;
  logic             rdv_q, fail_q, tmo_q;
  logic [7:0]       rdd_q, addr_byte, cmd1_byte, cmd2_byte;
  logic             accept, fire, last_xfer, dup_hit, t_ready, t_exp;

  assign req_op_e  = op_e'(req_op);
  assign req_ready = (state_q == S_IDLE) && !rdv_q;
  assign accept    = req_valid && req_ready;
  assign cnt_nxt   = {1'b0, cnt_q} + 1'b1;
  assign last_xfer = cnt_nxt >= {1'b0, len_q};

  nseq_addr_mux #(.COL_W(COL_W), .ROW_W(ROW_W)) u_amux (
    .col(col_q), .row(row_q), .idx(aidx_q), .abyte(addr_byte));

  nseq_busy_timer #(.TMO_W(TMO_W), .SETTLE(SETTLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == S_WAIT), .rb_n(rb_n),
    .limit(tmo_limit), .ready(t_ready), .expired(t_exp));

  nseq_prog_guard #(.ROW_W(ROW_W), .PAGE_BITS(PAGE_BITS), .TRACK_N(TRACK_N)) u_guard (
    .clk(clk), .rst_n(rst_n), .chk_row(req_row), .hit(dup_hit),
    .rec_en(accept && req_op_e == OP_PROG && !dup_hit), .rec_row(req_row),
    .clr_en(accept && req_op_e == OP_ERASE), .clr_row(req_row));

  always_comb begin
    case (op_q)
      OP_READ:  cmd1_byte = C_READ1;
      OP_PROG:  cmd1_byte = C_PROG1;
      OP_ERASE: cmd1_byte = C_ERASE1;
      OP_STAT:  cmd1_byte = C_STATUS;
      OP_ID:    cmd1_byte = C_IDENT;
      default:  cmd1_byte = C_RESET;
    endcase
    case (op_q)
      OP_READ:  cmd2_byte = C_READ2;
      OP_PROG:  cmd2_byte = C_PROG2;
      default:  cmd2_byte = C_ERASE2;
    endcase
  end

  always_comb begin
    cyc_valid = 1'b0;
    cyc_kind  = CK_CMD;
    cyc_byte  = 8'h00;
    case (state_q)
      S_CMD1:  begin cyc_valid = 1'b1; cyc_byte = cmd1_byte; end
      S_CMD2:  begin cyc_valid = 1'b1; cyc_byte = cmd2_byte; end
      S_STCMD: begin cyc_valid = 1'b1; cyc_byte = C_STATUS; end
      S_ADDR:  begin cyc_valid = 1'b1; cyc_kind = CK_ADDR; cyc_byte = addr_byte; end
      S_WDATA: begin cyc_valid = wr_valid; cyc_kind = CK_WR; cyc_byte = wr_data; end
      S_STRD:  begin cyc_valid = 1'b1; cyc_kind = CK_RD; end
      S_RDATA: begin cyc_valid = !rdv_q; cyc_kind = CK_RD; end
      default: ;
    endcase
  end

  assign fire     = cyc_valid && cyc_ready;
  assign wr_ready = (state_q == S_WDATA) && cyc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_READ;
      row_q   <= '0;
      col_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      aidx_q  <= '0;
      alast_q <= '0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      if (rdv_q && rd_ready) rdv_q <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          op_q    <= req_op_e;
          row_q   <= req_row;
          col_q   <= req_col;
          len_q   <= (req_op_e == OP_STAT) ? LEN_W'(1) : req_len;
          cnt_q   <= '0;
          aidx_q  <= (req_op_e == OP_ERASE) ? 3'd2 : (req_op_e == OP_ID) ? 3'd5 : 3'd0;
          alast_q <= (req_op_e == OP_ID) ? 3'd5 : 3'd4;
          tmo_q   <= 1'b0;
          if (req_op_e == OP_PROG && dup_hit) begin
            fail_q  <= 1'b1;
            state_q <= S_FINISH;
          end else begin
            fail_q  <= 1'b0;
            state_q <= S_CMD1;
          end
        end
        S_CMD1: if (fire) begin
          case (op_q)
            OP_RESET: state_q <= S_WAIT;
            OP_STAT:  state_q <= S_RDATA;
            default:  state_q <= S_ADDR;
          endcase
        end
        S_ADDR: if (fire) begin
          if (aidx_q == alast_q) begin
            case (op_q)
              OP_PROG: state_q <= S_WDATA;
              OP_ID:   state_q <= S_RDATA;
              default: state_q <= S_CMD2;
            endcase
          end else begin
            aidx_q <= aidx_q + 1'b1;
          end
        end
        S_WDATA: if (fire) begin
          cnt_q <= cnt_nxt[LEN_W-1:0];
          if (last_xfer) state_q <= S_CMD2;
        end
        S_CMD2:  if (fire) state_q <= S_WAIT;
        S_WAIT: begin
          if (t_ready) begin
            case (op_q)
              OP_READ:            state_q <= S_RDATA;
              OP_PROG, OP_ERASE:  state_q <= S_STCMD;
              default:            state_q <= S_FINISH;
            endcase
          end else if (t_exp) begin
            tmo_q   <= 1'b1;
            state_q <= S_FINISH;
          end
        end
        S_STCMD: if (fire) state_q <= S_STRD;
        S_STRD:  if (fire) state_q <= S_STWAIT;
        S_STWAIT: if (eng_rvalid) begin
          if (eng_rdata[ST_RDY_BIT]) begin
            fail_q  <= eng_rdata[ST_FAIL_BIT];
            state_q <= S_FINISH;
          end else begin
            state_q <= S_STRD;
          end
        end
        S_RDATA: if (fire) state_q <= S_RWAIT;
        S_RWAIT: if (eng_rvalid) begin
          rdv_q   <= 1'b1;
          rdd_q   <= eng_rdata;
          cnt_q   <= cnt_nxt[LEN_W-1:0];
          state_q <= last_xfer ? S_FINISH : S_RDATA;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;
  assign busy     = state_q != S_IDLE;
  assign done     = state_q == S_FINISH;
  assign op_fail  = fail_q;
  assign op_tmo   = tmo_q;

  // R11
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready && cyc_kind != CK_WR) |=>
      (cyc_valid && $stable(cyc_byte) && $stable(cyc_kind)));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  tmo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_tmo) |-> !$past(rb_n));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));
endmodule

// File: tb/tb_nand_op_seq.sv
module tb_nand_op_seq;
  localparam int RB_DLY   = 2;
  localparam int BUSY_LEN = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [23:0] req_row = '0;
  logic [15:0] req_col = '0;
  logic [13:0] req_len = '0;
  logic [19:0] tmo_limit = 20'd400;
  logic        cyc_valid, cyc_ready;
  logic [1:0]  cyc_kind;
  logic [7:0]  cyc_byte;
  logic        eng_rvalid = 1'b0;
  logic [7:0]  eng_rdata = '0;
  logic        rb_n;
  logic        wr_ready, rd_valid, busy, done, op_fail, op_tmo;
  logic [7:0]  wr_data, rd_data;
  logic        rd_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  // bench-side state
  logic       clr_logs = 1'b0;
  logic       stuck_rb = 1'b0;
  int         st_polls_cfg = 0;
  logic       st_fail_cfg = 1'b0;
  logic [1:0] log_k [64];
  logic [7:0] log_b [64];
  int         log_t [64];
  int         log_n = 0;
  logic [7:0] rx [64];
  int         rx_n = 0;
  int         cyc_no = 0;
  int         dly = 0, busyc = 0, polls_left = 0;
  logic [7:0] last_cmd = 8'h00;
  logic [7:0] rd_idx = 8'h00;
  logic [7:0] wr_idx = 8'h00;
  int         stall_ctr = 0;

  always #10 clk = ~clk;

  nand_op_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .tmo_limit(tmo_limit), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
    .cyc_kind(cyc_kind), .cyc_byte(cyc_byte), .eng_rvalid(eng_rvalid),
    .eng_rdata(eng_rdata), .rb_n(rb_n), .wr_valid(1'b1), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .op_fail(op_fail), .op_tmo(op_tmo));

  assign rb_n      = !(stuck_rb || (dly == 0 && busyc != 0));
  assign wr_data   = 8'h50 + wr_idx;
  assign cyc_ready = (stall_ctr != 0);

  always @(negedge clk) stall_ctr <= (stall_ctr == 2) ? 0 : stall_ctr + 1;

  // engine and device model
  always @(posedge clk) begin
    cyc_no <= cyc_no + 1;
    eng_rvalid <= 1'b0;
    if (dly != 0) dly <= dly - 1;
    else if (busyc != 0) busyc <= busyc - 1;
    if (cyc_valid && cyc_ready) begin
      if (cyc_kind == 2'd0) begin
        last_cmd <= cyc_byte;
        rd_idx   <= 8'h00;
        if (cyc_byte == 8'h70) polls_left <= st_polls_cfg;
        if (cyc_byte == 8'h30 || cyc_byte == 8'h10 || cyc_byte == 8'hD0 || cyc_byte == 8'hFF) begin
          dly   <= RB_DLY;
          busyc <= BUSY_LEN;
        end
      end
      if (cyc_kind == 2'd3) begin
        eng_rvalid <= 1'b1;
        if (last_cmd == 8'h70) begin
          if (polls_left > 0) begin
            eng_rdata  <= 8'h00;
            polls_left <= polls_left - 1;
          end else begin
            eng_rdata <= {1'b0, 1'b1, 5'b0, st_fail_cfg};
          end
        end else begin
          eng_rdata <= 8'hA0 + rd_idx;
          rd_idx    <= rd_idx + 1'b1;
        end
      end
    end
  end

  // logs
  always @(posedge clk) begin
    if (clr_logs) begin
      log_n  <= 0;
      rx_n   <= 0;
      wr_idx <= 8'h00;
    end else begin
      if (cyc_valid && cyc_ready && log_n < 64) begin
        log_k[log_n] <= cyc_kind;
        log_b[log_n] <= cyc_byte;
        log_t[log_n] <= cyc_no;
        log_n <= log_n + 1;
      end
      if (rd_valid && rd_ready && rx_n < 64) begin
        rx[rx_n] <= rd_data;
        rx_n <= rx_n + 1;
      end
      if (wr_ready) wr_idx <= wr_idx + 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic chk_log(input int i, input logic [1:0] k, input logic [7:0] b, input string req);
    chk_eq(req, {22'd0, log_k[i], log_b[i]}, {22'd0, k, b});
  endtask

  int t_acc;

  task automatic issue(input logic [2:0] op, input logic [23:0] row, input logic [15:0] col,
                       input logic [13:0] len);
    while (!req_ready) @(negedge clk);
    clr_logs  = 1'b1;
    req_op    = op;
    req_row   = row;
    req_col   = col;
    req_len   = len;
    req_valid = 1'b1;
    @(negedge clk);
    t_acc     = cyc_no;
    clr_logs  = 1'b0;
    req_valid = 1'b0;
    // R10
    chk(busy && !req_ready, "R10 busy after accept", {busy, req_ready}, 2'b10);
  endtask

  int t_done;

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    t_done = cyc_no;
    chk(done, "R12 done reached", done, 1);
    @(negedge clk);
    // R12
    chk_eq("R12 done single pulse", done, 0);
  endtask

  task automatic t_reset_state();
    // R1
    chk_eq("R1 reset outputs", {req_ready, busy, done, cyc_valid, rd_valid, op_fail, op_tmo},
           7'b1000000);
  endtask

  task automatic t_read();
    issue(3'd0, 24'h012345, 16'h0ABC, 14'd5);
    wait_done();
    chk_eq("R2 read cycle count", log_n, 12);
    chk_log(0, 2'd0, 8'h00, "R2 cmd 00h");
    chk_log(1, 2'd1, 8'hBC, "R2 col lo");
    chk_log(2, 2'd1, 8'h0A, "R2 col hi");
    chk_log(3, 2'd1, 8'h45, "R2 row 0");
    chk_log(4, 2'd1, 8'h23, "R2 row 1");
    chk_log(5, 2'd1, 8'h01, "R2 row 2");
    chk_log(6, 2'd0, 8'h30, "R2 cmd 30h");
    for (int i = 7; i < 12; i++) chk_log(i, 2'd3, 8'h00, "R2 read kind");
    // R13: first read must wait out the delayed busy period
    chk(log_t[7] - log_t[6] >= RB_DLY + BUSY_LEN, "R13 settle before ready",
        log_t[7] - log_t[6], RB_DLY + BUSY_LEN);
    chk_eq("R2 bytes received", rx_n, 5);
    for (int i = 0; i < 5; i++) chk_eq("R2 read data", rx[i], 8'hA0 + i);
    chk_eq("R2 no fail", op_fail, 0);
  endtask

  task automatic t_program();
    st_polls_cfg = 1;
    st_fail_cfg  = 1'b0;
    issue(3'd1, 24'h000102, 16'h0000, 14'd4);
    wait_done();
    chk_eq("R3 program cycle count", log_n, 14);
    chk_log(0, 2'd0, 8'h80, "R3 cmd 80h");
    chk_log(3, 2'd1, 8'h02, "R3 row 0");
    chk_log(4, 2'd1, 8'h01, "R3 row 1");
    for (int i = 0; i < 4; i++) chk_log(6 + i, 2'd2, 8'h50 + i, "R3 write data");
    chk_log(10, 2'd0, 8'h10, "R3 cmd 10h");
    chk_log(11, 2'd0, 8'h70, "R3 status cmd");
    chk_log(12, 2'd3, 8'h00, "R3 status poll 1");
    chk_log(13, 2'd3, 8'h00, "R3 status poll 2");
    chk_eq("R3 pass", op_fail, 0);
    st_polls_cfg = 0;
    st_fail_cfg  = 1'b1;
    issue(3'd1, 24'h000103, 16'h0000, 14'd2);
    wait_done();
    chk_eq("R3 fail bit", op_fail, 1);
    repeat (4) @(negedge clk);
    chk_eq("R12 fail held", op_fail, 1);
    st_fail_cfg = 1'b0;
  endtask

  task automatic t_dup();
    issue(3'd1, 24'h000102, 16'h0000, 14'd4);
    wait_done();
    chk_eq("R5 no cycles on reject", log_n, 0);
    chk_eq("R5 reject fail", op_fail, 1);
  endtask

  task automatic t_erase();
    issue(3'd2, 24'h000155, 16'h0000, 14'd0);
    wait_done();
    chk_eq("R4 erase cycle count", log_n, 7);
    chk_log(0, 2'd0, 8'h60, "R4 cmd 60h");
    chk_log(1, 2'd1, 8'h55, "R4 row 0");
    chk_log(2, 2'd1, 8'h01, "R4 row 1");
    chk_log(3, 2'd1, 8'h00, "R4 row 2");
    chk_log(4, 2'd0, 8'hD0, "R4 cmd D0h");
    chk_log(5, 2'd0, 8'h70, "R4 status cmd");
    chk_eq("R4 pass", op_fail, 0);
    issue(3'd1, 24'h000102, 16'h0000, 14'd4);
    wait_done();
    chk_eq("R4 reprogram after erase", log_n, 13);
    chk_eq("R4 reprogram pass", op_fail, 0);
  endtask

  task automatic t_status();
    issue(3'd3, 24'h0, 16'h0, 14'd9);
    wait_done();
    chk_eq("R6 status cycles", log_n, 2);
    chk_log(0, 2'd0, 8'h70, "R6 cmd 70h");
    chk_eq("R6 one byte", rx_n, 1);
    chk_eq("R6 status byte", rx[0], 8'h40);
  endtask

  task automatic t_ident();
    issue(3'd4, 24'h123456, 16'h7777, 14'd3);
    wait_done();
    chk_eq("R7 id cycles", log_n, 5);
    chk_log(0, 2'd0, 8'h90, "R7 cmd 90h");
    chk_log(1, 2'd1, 8'h00, "R7 addr 00h");
    chk_eq("R7 id bytes", rx_n, 3);
    for (int i = 0; i < 3; i++) chk_eq("R7 id data", rx[i], 8'hA0 + i);
  endtask

  task automatic t_dev_reset();
    issue(3'd5, 24'h0, 16'h0, 14'd0);
    wait_done();
    chk_eq("R8 reset cycles", log_n, 1);
    chk_log(0, 2'd0, 8'hFF, "R8 cmd FFh");
    chk(t_done - t_acc >= RB_DLY + BUSY_LEN, "R8 waits for ready", t_done - t_acc,
        RB_DLY + BUSY_LEN);
    chk_eq("R8 pass", {op_fail, op_tmo}, 2'b00);
  endtask

  task automatic t_timeout();
    tmo_limit = 20'd20;
    stuck_rb  = 1'b1;
    issue(3'd2, 24'h000200, 16'h0, 14'd0);
    wait_done();
    chk_eq("R9 timeout flag", op_tmo, 1);
    chk_eq("R9 no cycles after wait", log_n, 5);
    repeat (5) @(negedge clk);
    chk_eq("R12 tmo held", op_tmo, 1);
    chk_eq("R9 nothing issued later", log_n, 5);
    stuck_rb  = 1'b0;
    tmo_limit = 20'd400;
    issue(3'd5, 24'h0, 16'h0, 14'd0);
    wait_done();
    chk_eq("R12 tmo cleared by next request", op_tmo, 0);
  endtask

  task automatic t_backpressure();
    logic [7:0] held;
    int n = 0;
    rd_ready = 1'b0;
    issue(3'd0, 24'h000010, 16'h0004, 14'd3);
    while (!rd_valid && n < 500) begin
      @(negedge clk);
      n++;
    end
    held = rd_data;
    repeat (8) @(negedge clk);
    // R11
    chk_eq("R11 byte held", {rd_valid, rd_data}, {1'b1, held});
    chk_eq("R11 no read issued while full", log_n, 8);
    rd_ready = 1'b1;
    wait_done();
    @(negedge clk);
    chk_eq("R11 bytes after release", rx_n, 3);
    for (int i = 0; i < 3; i++) chk_eq("R11 data order", rx[i], 8'hA0 + i);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read();
    t_program();
    t_dup();
    t_erase();
    t_status();
    t_ident();
    t_dev_reset();
    t_timeout();
    t_backpressure();
    summary();
  end
endmodule